// File: doc/BRIEF.md
# Periodic Battery-Low Checker

This block decides when the backup cell of a battery-backed memory supervisor gets tested, and it holds the verdict. An external comparator reports, as a single digital level, whether the cell sits under its threshold (nominally around 2.5 V). The block enables that comparator through a sample strobe and registers its answer onto an active-high battery-low flag. The flag stands for the asserted state of an open-drain indicator pin.

A test starts every time the supply turns good. While the supply stays good, further tests repeat at a long fixed spacing, a day or more, counted in clock cycles. Between tests the flag holds its value. Fitting a fresh cell therefore shows up only at the next scheduled or power-up test. While the system runs from the cell, no test runs and the spacing count stands still. A test-mode input swaps in a short spacing so that periodic tests can be watched in a simulation of practical length.

Top module: `bw_top`

## Requirements
- R1: While reset is asserted, sample_en_o and batt_low_o are both 0.
- R2: In the first clock cycle where pwr_good_i is sampled high and was low (or in reset) at the previous edge, a test starts: sample_en_o is 1 from the next cycle on.
- R3: A test drives sample_en_o high for exactly SETTLE_CYC consecutive cycles. Only the value of below_thresh_i (1 means below threshold) in the last of those cycles is written to batt_low_o, which shows it one cycle later.
- R4: batt_low_o changes only at the end of a completed test. Changes of below_thresh_i outside the last window cycle, such as a cell replacement, have no effect until the next test.
- R5: With test_mode_i low and power good, the next test starts after exactly INTERVAL_CYC idle cycles counted from the end of the previous test.
- R6: While pwr_good_i is low, no test starts and batt_low_o holds its value.
- R7: If pwr_good_i is sampled low during a test, sample_en_o drops in the next cycle and batt_low_o keeps its previous value.
- R8: The spacing count restarts from zero after each power-up test, whatever count was reached before the supply dropped.
- R9: With test_mode_i high, the spacing is TEST_INTERVAL idle cycles instead of INTERVAL_CYC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Main supply within tolerance |
| test_mode_i | input | 1 | Selects the short test spacing |
| below_thresh_i | input | 1 | Comparator verdict: 1 means the cell is under its threshold |
| sample_en_o | output | 1 | Enables the external comparator during a test window |
| batt_low_o | output | 1 | Latched battery-low indication, active high |

## Verification
The bench goes after the final-cycle capture rule. It holds the comparator answer opposite to the final value for all but the last window cycle, so a design that samples too early or ORs across the window ends with the wrong flag. It cuts power in the middle of a window: a design that still finishes the test, or clears the flag, shows it at the flag or the strobe. It flips the comparator between tests to catch a flag that is not sticky. It also checks the exact spacing in both modes and after a power cycle, where a counter that runs on battery or resumes a stale count starts the periodic test at the wrong cycle.

// File: rtl/bw_pkg.sv
package bw_pkg;

   typedef enum logic {
      SEQ_IDLE   = 1'b0,
      SEQ_SAMPLE = 1'b1
   } seq_state_e;

   // one day at a 32768 Hz timebase
   localparam longint unsigned DEFAULT_SPACING = 64'd2831155200;

endpackage

// File: rtl/bw_interval_timer.sv
module bw_interval_timer #(
   parameter longint unsigned INTERVAL_CYC  = 64'd2831155200,
   parameter int unsigned     TEST_INTERVAL = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hold_zero_i,
   input  logic enable_i,
   input  logic test_mode_i,
   output logic due_o
);

   localparam int unsigned CNT_W = $clog2(INTERVAL_CYC) + 1;
   localparam logic [CNT_W-1:0] LAST_NORMAL = CNT_W'(INTERVAL_CYC - 1);
   localparam logic [CNT_W-1:0] LAST_TEST   = CNT_W'(TEST_INTERVAL - 1);

   if (TEST_INTERVAL < 2) begin : g_bad_test
      $error("TEST_INTERVAL must be at least 2");
   end
   if (longint'(TEST_INTERVAL) > INTERVAL_CYC) begin : g_bad_order
      $error("TEST_INTERVAL must not exceed INTERVAL_CYC");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;

   assign last_val = test_mode_i ? LAST_TEST : LAST_NORMAL;
   assign due_o    = enable_i && (cnt_q >= last_val);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (hold_zero_i || due_o) begin
         cnt_q <= '0;
      end else if (enable_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/bw_sample_seq.sv
module bw_sample_seq
   import bw_pkg::*;
#(
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_good_i,
   input  logic start_i,
   output logic busy_o,
   output logic capture_o
);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   seq_state_e state_q;
   seq_state_e state_d;
   logic       last_cyc;

   if (SETTLE_CYC == 1) begin : g_single
      assign last_cyc = 1'b1;
   end else begin : g_count
      localparam int unsigned WIN_W = $clog2(SETTLE_CYC);
      localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SETTLE_CYC - 1);
      logic [WIN_W-1:0] win_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            win_q <= '0;
         end else if (state_q == SEQ_IDLE) begin
            win_q <= '0;
         end else if (!last_cyc) begin
            win_q <= win_q + 1'b1;
         end
      end

      assign last_cyc = (win_q == WIN_LAST);
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE:   if (start_i) state_d = SEQ_SAMPLE;
         SEQ_SAMPLE: if (!pwr_good_i || last_cyc) state_d = SEQ_IDLE;
         default:    state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= SEQ_IDLE;
      else         state_q <= state_d;
   end

   assign busy_o    = (state_q == SEQ_SAMPLE);
   assign capture_o = busy_o && pwr_good_i && last_cyc;

endmodule

// File: rtl/bw_flag_hold.sv
module bw_flag_hold #(
   parameter bit FLAG_RESET = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic capture_i,
   input  logic below_i,
   output logic flag_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o <= FLAG_RESET;
      else if (capture_i) flag_o <= below_i;
   end

endmodule

// File: rtl/bw_top.sv
module bw_top #(
   parameter longint unsigned INTERVAL_CYC  = bw_pkg::DEFAULT_SPACING,
   parameter int unsigned     TEST_INTERVAL = 16,
   parameter int unsigned     SETTLE_CYC    = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_good_i,
   input  logic test_mode_i,
   input  logic below_thresh_i,
   output logic sample_en_o,
   output logic batt_low_o
);

   logic pg_q;
   logic pg_rise;
   logic busy;
   logic capture;
   logic due;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pg_q <= 1'b0;
      else         pg_q <= pwr_good_i;
   end

   assign pg_rise = pwr_good_i && !pg_q;

   bw_interval_timer #(
      .INTERVAL_CYC (INTERVAL_CYC),
      .TEST_INTERVAL(TEST_INTERVAL)
   ) i_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hold_zero_i(busy),
      .enable_i   (pwr_good_i && !busy),
      .test_mode_i(test_mode_i),
      .due_o      (due)
   );

   bw_sample_seq #(
      .SETTLE_CYC(SETTLE_CYC)
   ) i_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pwr_good_i(pwr_good_i),
      .start_i   (pg_rise || due),
      .busy_o    (busy),
      .capture_o (capture)
   );

   bw_flag_hold #(
      .FLAG_RESET(1'b0)
   ) i_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .capture_i(capture),
      .below_i  (below_thresh_i),
      .flag_o   (batt_low_o)
   );

   assign sample_en_o = busy;

endmodule

module bw_checker #(
   parameter int unsigned SETTLE_CYC = 4
) (
   input logic clk_i,
   input logic rst_ni,
   input logic pwr_good_i,
   input logic pg_q,
   input logic sample_en_o,
   input logic batt_low_o
);

   localparam int unsigned RUN_W = $clog2(SETTLE_CYC + 2) + 1;
   logic [RUN_W-1:0] run_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          run_cnt <= '0;
      else if (sample_en_o) run_cnt <= run_cnt + 1'b1;
      else                  run_cnt <= '0;
   end

   // R2
   a_r2_powerup_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_good_i && !pg_q |=> sample_en_o);

   // R3
   a_r3_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_cnt <= RUN_W'(SETTLE_CYC));

   // R4
   a_r4_flag_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(batt_low_o) |-> $past(sample_en_o));

   // R6
   a_r6_no_strobe_unpowered: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_good_i |=> !sample_en_o);

   // R6
   a_r6_flag_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_good_i |=> $stable(batt_low_o));

   // R7
   a_r7_abort_keeps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_en_o && !pwr_good_i |=> $stable(batt_low_o) && !sample_en_o);

endmodule

bind bw_top bw_checker #(.SETTLE_CYC(SETTLE_CYC)) i_bw_checker (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .pwr_good_i (pwr_good_i),
   .pg_q       (pg_q),
   .sample_en_o(sample_en_o),
   .batt_low_o (batt_low_o)
);

// File: tb/test_bw_top.sv
`timescale 1ns/1ps
module test_bw_top;

   localparam int unsigned SPACING = 60;
   localparam int unsigned SHORT   = 12;
   localparam int unsigned SETTLE  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pg = 1'b0;
   logic tmode = 1'b1;
   logic below = 1'b0;
   logic sample_en;
   logic batt_low;

   always #2 clk = ~clk;

   bw_top #(
      .INTERVAL_CYC (SPACING),
      .TEST_INTERVAL(SHORT),
      .SETTLE_CYC   (SETTLE)
   ) i_bw_top (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .pwr_good_i    (pg),
      .test_mode_i   (tmode),
      .below_thresh_i(below),
      .sample_en_o   (sample_en),
      .batt_low_o    (batt_low)
   );

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string cur_req = "R1";

   // behavioural reference
   bit m_busy = 0;
   bit m_flag = 0;
   bit m_pg_prev = 0;
   int m_win = 0;
   int m_idle = 0;

   always @(posedge clk) begin
      int lim;
      lim = tmode ? SHORT : SPACING;
      if (!rst_n) begin
         m_busy = 0; m_flag = 0; m_pg_prev = 0; m_win = 0; m_idle = 0;
      end else begin
         if (m_busy) begin
            if (!pg) begin
               m_busy = 0; m_idle = 0;
            end else if (m_win == SETTLE) begin
               m_busy = 0; m_flag = below; m_idle = 0;
            end else begin
               m_win++;
            end
         end else if (pg) begin
            if (!m_pg_prev || m_idle >= lim - 1) begin
               m_busy = 1; m_win = 1; m_idle = 0;
            end else begin
               m_idle++;
            end
         end
         m_pg_prev = pg;
      end
   end

   always @(negedge clk) begin
      cycles++;
      checks++;
      if (sample_en !== m_busy) begin
         errors++;
         $display("FAIL %s sample_en_o actual=%b expected=%b at cycle %0d", cur_req, sample_en, m_busy, cycles);
      end
      checks++;
      if (batt_low !== m_flag) begin
         errors++;
         $display("FAIL %s batt_low_o actual=%b expected=%b at cycle %0d", cur_req, batt_low, m_flag, cycles);
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!sample_en);
   endtask

   task automatic direct_check(input string req, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s directed actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      wait_cyc(4000);
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
   end

   initial begin
      // R1: outputs low in reset even with power good
      cur_req = "R1";
      pg = 1'b1;
      wait_cyc(4);
      direct_check("R1", sample_en, 1'b0);
      pg = 1'b0;
      wait_cyc(2);
      rst_n = 1'b1;

      // R6: unpowered, nothing happens
      cur_req = "R6";
      below = 1'b1;
      wait_cyc(6);
      direct_check("R6", sample_en, 1'b0);

      // R2 / R3: power-up test latches low battery
      cur_req = "R2";
      pg = 1'b1;
      @(negedge clk);
      direct_check("R2", sample_en, 1'b1);
      cur_req = "R3";
      wait_cyc(SETTLE);
      direct_check("R3", batt_low, 1'b1);

      // R9: short spacing, several periodic tests
      cur_req = "R9";
      wait_cyc(3 * (SHORT + SETTLE));

      // R3: only the final window cycle counts
      cur_req = "R3";
      wait_strobe();
      below = 1'b1;
      wait_cyc(SETTLE - 1);
      below = 1'b0;
      wait_cyc(1);
      below = 1'b1;
      @(negedge clk);
      direct_check("R3", batt_low, 1'b0);
      wait_strobe();
      below = 1'b0;
      wait_cyc(SETTLE - 1);
      below = 1'b1;
      wait_cyc(2);
      direct_check("R3", batt_low, 1'b1);

      // R4 / R5: normal spacing, replacement does not clear until next test
      cur_req = "R5";
      tmode = 1'b0;
      wait_strobe();
      wait_cyc(SETTLE + 2);
      cur_req = "R4";
      below = 1'b0;
      wait_cyc(30);
      direct_check("R4", batt_low, 1'b1);
      below = 1'b1;
      wait_cyc(3);
      below = 1'b0;
      cur_req = "R5";
      wait_strobe();
      wait_cyc(SETTLE);
      direct_check("R5", batt_low, 1'b0);

      // R7: power drops mid-window
      cur_req = "R7";
      tmode = 1'b1;
      wait_strobe();
      below = 1'b1;
      wait_cyc(1);
      pg = 1'b0;
      @(negedge clk);
      direct_check("R7", sample_en, 1'b0);
      cur_req = "R6";
      wait_cyc(20);
      direct_check("R6", batt_low, 1'b0);

      // R8: spacing restarts after power-up test, partial count discarded
      cur_req = "R8";
      pg = 1'b1;
      wait_cyc(SETTLE + 5);
      pg = 1'b0;
      wait_cyc(5);
      below = 1'b0;
      pg = 1'b1;
      wait_cyc(3 * (SHORT + SETTLE) + 4);

      // R6: drop during idle spacing
      cur_req = "R6";
      wait_cyc(3);
      pg = 1'b0;
      below = 1'b1;
      wait_cyc(40);
      direct_check("R6", batt_low, 1'b0);
      cur_req = "R2";
      pg = 1'b1;
      wait_cyc(SETTLE + 2);
      direct_check("R2", batt_low, 1'b1);

      finish_run();
   end

endmodule